// File: doc/BRIEF.md
# USB Host Receive Endpoint Control and Status

This block is the receive-side control and status logic for one endpoint of a USB host controller. Software reads and writes an 8-bit control/status byte. A protocol engine reports the outcome of each transaction as a one-cycle event: a clean data packet, a data packet with a CRC or bit-stuff fault, a STALL handshake, a NAK, or a timeout with no data. The block drives a request line that asks the engine for IN transactions. It also produces one-cycle pulses that clear the endpoint's data toggle, raise the endpoint interrupt, and tell the receive buffer to drop one packet.

The receive buffer holds one or two packets, chosen at run time. The block counts how many packets are buffered and counts failed attempts toward a three-strike error. For bulk transfers it measures how many frames a run of NAKs has lasted. Bit 3 of the byte has two meanings. On an isochronous endpoint it flags the buffered packet as corrupted. On a bulk endpoint it flags that the endpoint halted because NAKs went on too long.

Top module: `usb_host_rx_ep_ctrl`

Byte layout, from bit 7 down to bit 0:
- toggle-clear (reads 0)
- stalled
- request
- flush (reads 0)
- data-error / NAK-halt
- error
- full
- ready

## Requirements
- R1: After reset the byte reads 0x00, and `in_req`, `toggle_clr`, `ep_irq` and `fifo_flush` are all 0.
- R2: A write with bit 7 = 1 pulses `toggle_clr` high for exactly one cycle, in the cycle after the write. A write with bit 7 = 0 gives no pulse. Bit 7 always reads 0.
- R3: A STALL event sets bit 6, clears bit 5 and pulses `ep_irq` in the next cycle. A write with bit 6 = 0 clears bit 6. A write with bit 6 = 1 leaves it unchanged.
- R4: Writing 1 to bit 5 sets bit 5 and `in_req`. The bit clears when a data packet is accepted and ready (bit 0) goes high.
- R5: Every accepted packet increments the occupancy count. Ready (bit 0) is count > 0. Full (bit 1) is count equal to the capacity: 1 when `cfg_double_buf` = 0, 2 when it is 1. A packet that arrives while full is dropped.
- R6: A one-cycle `sw_rd_done` strobe removes one packet from the count.
- R7: A write with bit 4 = 1 while ready is set pulses `fifo_flush` and removes exactly one packet. With two packets buffered, two flushes are needed to empty the buffer. With nothing buffered the flush is ignored and no pulse is produced.
- R8: On an isochronous endpoint (`cfg_iso` = 1), a corrupted packet is accepted and sets bit 3 together with ready. Bit 3 clears when the count returns to 0.
- R9: On a non-isochronous endpoint, three failed attempts in a row set bit 2, clear bit 5 and pulse `ep_irq`. A failed attempt is a timeout, or a corrupted packet, which is not stored. Only a write of 0 to bit 2 clears the bit. In isochronous mode bit 2 reads 0 and timeouts are ignored.
- R10: The failed-attempt count restarts from 0 on a clean packet and on every accepted write of 1 to bit 5.
- R11: On a bulk endpoint with `nak_limit` = N and N >= 2, bit 3 sets and bit 5 clears once NAKs have continued for 2^(N-1) `sof_tick` frames. N of 0 or 1 disables this timeout. Any non-NAK outcome restarts the frame count.
- R12: While bit 6 is set, or while bit 3 is set on a bulk endpoint, a write of 1 to bit 5 is ignored and `in_req` stays low.
- R13: On a bulk endpoint a write of 0 to bit 3 clears it. On an isochronous endpoint writes have no effect on bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_iso | input | 1 | 1 = isochronous endpoint, 0 = bulk/interrupt |
| cfg_double_buf | input | 1 | 1 = buffer holds two packets, 0 = one |
| nak_limit | input | 5 | NAK timeout exponent N (2^(N-1) frames) |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wdata | input | 8 | Software write data |
| sw_rdata | output | 8 | Control/status byte |
| sw_rd_done | input | 1 | Software finished reading one packet |
| ev_pkt_ok | input | 1 | Clean data packet received |
| ev_pkt_crc_err | input | 1 | Data packet with CRC or bit-stuff error |
| ev_stall | input | 1 | STALL handshake received |
| ev_nak | input | 1 | NAK handshake received |
| ev_timeout | input | 1 | Attempt ended with no data |
| sof_tick | input | 1 | Start of a new frame |
| in_req | output | 1 | Request IN transactions |
| toggle_clr | output | 1 | Clear data toggle, one-cycle pulse |
| ep_irq | output | 1 | Endpoint interrupt, one-cycle pulse |
| fifo_flush | output | 1 | Drop one buffered packet, one-cycle pulse |

## Verification
The hardest state to reach from the ports is the bulk NAK halt, together with the check that a single non-NAK response in the middle of a NAK run restarts the frame count. The stimulus sets a small limit (N = 2) so that expiry takes only a couple of frame ticks. It then replays the same NAK run with a timeout event inserted between frame ticks, and checks that bit 3 stays clear. The three-strike error is reached in a similar way: two timeouts and then a corrupted bulk packet. Before that, an extra request write is placed in the middle of the run to show that the count restarts.

// File: rtl/rx_ep_pkg.sv
package rx_ep_pkg;
  localparam int CSR_W   = 8;
  localparam int F_RDY   = 0;
  localparam int F_FULL  = 1;
  localparam int F_ERR   = 2;
  localparam int F_B3    = 3;
  localparam int F_FLUSH = 4;
  localparam int F_REQ   = 5;
  localparam int F_STALL = 6;
  localparam int F_TGL   = 7;

  typedef struct packed {
    logic stalled;
    logic req;
    logic flag3;
    logic err;
    logic full;
    logic rdy;
  } ep_state_t;

  function automatic logic [CSR_W-1:0] pack_csr(input ep_state_t s);
    logic [CSR_W-1:0] v;
    v          = '0;
    v[F_STALL] = s.stalled;
    v[F_REQ]   = s.req;
    v[F_B3]    = s.flag3;
    v[F_ERR]   = s.err;
    v[F_FULL]  = s.full;
    v[F_RDY]   = s.rdy;
    return v;
  endfunction
endpackage

// File: rtl/rx_occ_tracker.sv
module rx_occ_tracker #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cap,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] count_nxt,
  output logic             rxrdy,
  output logic             full
);
  logic [CNT_W-1:0] count;
  logic take_in, take_out;

  always_comb begin
    take_in  = inc && (count != cap);
    take_out = dec && (count != '0);
    count_nxt = count;
    if (take_in && !take_out)      count_nxt = count + CNT_W'(1);
    else if (take_out && !take_in) count_nxt = count - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count_nxt;
  end

  assign rxrdy = (count != '0);
  assign full  = (count == cap);
endmodule

// File: rtl/rx_retry_tracker.sv
module rx_retry_tracker #(
  parameter int RETRY_MAX = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic fail,
  output logic hit
);
  localparam int RW = $clog2(RETRY_MAX + 1);
  logic [RW-1:0] tries;

  assign hit = fail && !clear && (tries == RW'(RETRY_MAX - 1));

  always_ff @(posedge clk) begin
    if (rst || clear || hit) tries <= '0;
    else if (fail)           tries <= tries + RW'(1);
  end
endmodule

// File: rtl/rx_nak_timer.sv
module rx_nak_timer #(
  parameter int LIM_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             nak,
  input  logic             other_resp,
  input  logic             sof,
  input  logic [LIM_W-1:0] limit,
  output logic             expire
);
  localparam int FRM_W = (1 << LIM_W) - 1;
  logic             active;
  logic [FRM_W-1:0] frames;
  logic [FRM_W-1:0] target;
  logic             limit_ok;

  assign limit_ok = (limit > LIM_W'(1));
  assign target   = FRM_W'(1) << (limit - LIM_W'(1));
  assign expire   = enable && !other_resp && active && sof && limit_ok &&
                    ((frames + FRM_W'(1)) == target);

  always_ff @(posedge clk) begin
    if (rst || !enable || other_resp) begin
      active <= 1'b0;
      frames <= '0;
    end else if (!active) begin
      if (nak) begin
        active <= 1'b1;
        frames <= '0;
      end
    end else if (sof) begin
      if (expire) begin
        active <= 1'b0;
        frames <= '0;
      end else begin
        frames <= frames + FRM_W'(1);
      end
    end
  end
endmodule

// File: rtl/usb_host_rx_ep_ctrl.sv
module usb_host_rx_ep_ctrl
  import rx_ep_pkg::*;
#(
  parameter int LIM_W     = 5,
  parameter int CNT_W     = 2,
  parameter int RETRY_MAX = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_iso,
  input  logic             cfg_double_buf,
  input  logic [LIM_W-1:0] nak_limit,
  input  logic             sw_wr_en,
  input  logic [CSR_W-1:0] sw_wdata,
  output logic [CSR_W-1:0] sw_rdata,
  input  logic             sw_rd_done,
  input  logic             ev_pkt_ok,
  input  logic             ev_pkt_crc_err,
  input  logic             ev_stall,
  input  logic             ev_nak,
  input  logic             ev_timeout,
  input  logic             sof_tick,
  output logic             in_req,
  output logic             toggle_clr,
  output logic             ep_irq,
  output logic             fifo_flush
);
  logic             stalled_q, req_q, flag3_q, err_q;
  logic [CNT_W-1:0] cap, count_nxt;
  logic             rxrdy, full;
  logic             pkt_accept, flush_go, req_set, blocked;
  logic             retry_clear, retry_fail, retry_hit;
  logic             nak_en, nak_other, nak_expire;
  logic             iso_bad_store;
  logic             unused_ro_bits;
  ep_state_t        st;

  assign unused_ro_bits = ^sw_wdata[F_FULL:F_RDY];

  assign cap           = cfg_double_buf ? CNT_W'(2) : CNT_W'(1);
  assign pkt_accept    = ev_pkt_ok || (cfg_iso && ev_pkt_crc_err);
  assign flush_go      = sw_wr_en && sw_wdata[F_FLUSH] && rxrdy;
  assign blocked       = stalled_q || (!cfg_iso && flag3_q);
  assign req_set       = sw_wr_en && sw_wdata[F_REQ] && !blocked;
  assign retry_clear   = ev_pkt_ok || req_set;
  assign retry_fail    = !cfg_iso && (ev_timeout || ev_pkt_crc_err);
  assign nak_en        = !cfg_iso && !flag3_q;
  assign nak_other     = ev_pkt_ok || ev_pkt_crc_err || ev_stall || ev_timeout;
  assign iso_bad_store = cfg_iso && ev_pkt_crc_err && !full;

  rx_occ_tracker #(.CNT_W(CNT_W)) u_occ (
    .clk       (clk),
    .rst       (rst),
    .cap       (cap),
    .inc       (pkt_accept),
    .dec       (sw_rd_done || flush_go),
    .count_nxt (count_nxt),
    .rxrdy     (rxrdy),
    .full      (full)
  );

  rx_retry_tracker #(.RETRY_MAX(RETRY_MAX)) u_retry (
    .clk   (clk),
    .rst   (rst),
    .clear (retry_clear),
    .fail  (retry_fail),
    .hit   (retry_hit)
  );

  rx_nak_timer #(.LIM_W(LIM_W)) u_nak (
    .clk        (clk),
    .rst        (rst),
    .enable     (nak_en),
    .nak        (ev_nak),
    .other_resp (nak_other),
    .sof        (sof_tick),
    .limit      (nak_limit),
    .expire     (nak_expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stalled_q  <= 1'b0;
      req_q      <= 1'b0;
      flag3_q    <= 1'b0;
      err_q      <= 1'b0;
      toggle_clr <= 1'b0;
      ep_irq     <= 1'b0;
      fifo_flush <= 1'b0;
    end else begin
      toggle_clr <= sw_wr_en && sw_wdata[F_TGL];
      fifo_flush <= flush_go;
      ep_irq     <= ev_stall || retry_hit;

      if (ev_stall)                              stalled_q <= 1'b1;
      else if (sw_wr_en && !sw_wdata[F_STALL])   stalled_q <= 1'b0;

      if (pkt_accept || ev_stall || retry_hit || nak_expire) req_q <= 1'b0;
      else if (sw_wr_en)                                     req_q <= req_set;

      if (cfg_iso) begin
        if (iso_bad_store)                       flag3_q <= 1'b1;
        else if (count_nxt == '0)                flag3_q <= 1'b0;
      end else begin
        if (nak_expire)                          flag3_q <= 1'b1;
        else if (sw_wr_en && !sw_wdata[F_B3])    flag3_q <= 1'b0;
      end

      if (retry_hit)                             err_q <= 1'b1;
      else if (sw_wr_en && !sw_wdata[F_ERR])     err_q <= 1'b0;
    end
  end

  always_comb begin
    st.stalled = stalled_q;
    st.req     = req_q;
    st.flag3   = flag3_q;
    st.err     = err_q && !cfg_iso;
    st.full    = full;
    st.rdy     = rxrdy;
  end

  assign sw_rdata = pack_csr(st);
  assign in_req   = req_q;
endmodule

// File: rtl/usb_host_rx_ep_ctrl_chk.sv
module usb_host_rx_ep_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_iso,
  input logic       sw_wr_en,
  input logic [7:0] sw_wdata,
  input logic [7:0] sw_rdata,
  input logic       ev_stall,
  input logic       in_req,
  input logic       toggle_clr,
  input logic       ep_irq,
  input logic       fifo_flush
);
  p_tgl_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    (sw_wr_en && sw_wdata[7]) |=> toggle_clr);
  p_tgl_reads_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !sw_rdata[7]);
  p_stall_irq_r3: assert property (@(posedge clk) disable iff (rst)
    ev_stall |=> (sw_rdata[6] && ep_irq && !in_req));
  p_req_drops_on_rdy_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_rdata[0]) |-> !in_req);
  p_full_has_data_r5: assert property (@(posedge clk) disable iff (rst)
    sw_rdata[1] |-> sw_rdata[0]);
  p_flush_needs_data_r7: assert property (@(posedge clk) disable iff (rst)
    fifo_flush |-> $past(sw_rdata[0]));
  p_iso_err_zero_r9: assert property (@(posedge clk) disable iff (rst)
    cfg_iso |-> !sw_rdata[2]);
  p_stall_blocks_req_r12: assert property (@(posedge clk) disable iff (rst)
    (sw_rdata[6] && !ev_stall && sw_wr_en && sw_wdata[5] && sw_wdata[6]) |=> !in_req);
endmodule

bind usb_host_rx_ep_ctrl usb_host_rx_ep_ctrl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_iso    (cfg_iso),
  .sw_wr_en   (sw_wr_en),
  .sw_wdata   (sw_wdata),
  .sw_rdata   (sw_rdata),
  .ev_stall   (ev_stall),
  .in_req     (in_req),
  .toggle_clr (toggle_clr),
  .ep_irq     (ep_irq),
  .fifo_flush (fifo_flush)
);

// File: tb/usb_host_rx_ep_ctrl_tb_top.sv
module usb_host_rx_ep_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_iso = 1'b0, cfg_double_buf = 1'b0;
  logic [4:0] nak_limit = 5'd0;
  logic       sw_wr_en = 1'b0;
  logic [7:0] sw_wdata = 8'h00;
  logic [7:0] sw_rdata;
  logic       sw_rd_done = 1'b0;
  logic       ev_pkt_ok = 1'b0, ev_pkt_crc_err = 1'b0, ev_stall = 1'b0;
  logic       ev_nak = 1'b0, ev_timeout = 1'b0, sof_tick = 1'b0;
  logic       in_req, toggle_clr, ep_irq, fifo_flush;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    string      tag;
    logic [7:0] rd;
    logic [3:0] outs;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  usb_host_rx_ep_ctrl dut_i (
    .clk(clk), .rst(rst), .cfg_iso(cfg_iso), .cfg_double_buf(cfg_double_buf),
    .nak_limit(nak_limit), .sw_wr_en(sw_wr_en), .sw_wdata(sw_wdata),
    .sw_rdata(sw_rdata), .sw_rd_done(sw_rd_done), .ev_pkt_ok(ev_pkt_ok),
    .ev_pkt_crc_err(ev_pkt_crc_err), .ev_stall(ev_stall), .ev_nak(ev_nak),
    .ev_timeout(ev_timeout), .sof_tick(sof_tick), .in_req(in_req),
    .toggle_clr(toggle_clr), .ep_irq(ep_irq), .fifo_flush(fifo_flush)
  );

  // Monitor: pops one expectation per cycle, away from the active edge.
  always @(negedge clk) begin
    if (!done && sb.size() > 0) begin
      exp_t e;
      logic [3:0] got;
      e   = sb.pop_front();
      got = {in_req, toggle_clr, ep_irq, fifo_flush};
      checks++;
      if (sw_rdata !== e.rd || got !== e.outs) begin
        errors++;
        $display("FAIL %s: rdata=%h outs=%b expected rdata=%h outs=%b",
                 e.tag, sw_rdata, got, e.rd, e.outs);
      end
    end
  end

  task automatic go();
    @(posedge clk);
    #1;
    sw_wr_en = 0; sw_rd_done = 0; ev_pkt_ok = 0; ev_pkt_crc_err = 0;
    ev_stall = 0; ev_nak = 0; ev_timeout = 0; sof_tick = 0;
  endtask

  // Driver: one cycle of stimulus, then queue what must be seen after it.
  task automatic expect_after(string tag, logic [7:0] rd, logic [3:0] outs);
    go();
    sb.push_back('{tag, rd, outs});
  endtask

  task automatic wr(logic [7:0] d);
    sw_wr_en = 1; sw_wdata = d;
  endtask

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    expect_after("R1 reset state", 8'h00, 4'b0000);
    // R2 toggle clear
    wr(8'h80);  expect_after("R2 toggle pulse", 8'h00, 4'b0100);
                expect_after("R2 pulse ends", 8'h00, 4'b0000);
    wr(8'h00);  expect_after("R2 zero write no pulse", 8'h00, 4'b0000);
    // R4 / R5 / R6 single buffer
    wr(8'h20);  expect_after("R4 request set", 8'h20, 4'b1000);
    ev_pkt_ok = 1; expect_after("R4 R5 packet clears request, full", 8'h03, 4'b0000);
    ev_pkt_ok = 1; expect_after("R5 packet dropped when full", 8'h03, 4'b0000);
    sw_rd_done = 1; expect_after("R6 read done empties", 8'h00, 4'b0000);
    // R5 / R7 double buffer
    cfg_double_buf = 1;
    ev_pkt_ok = 1; expect_after("R5 double first packet", 8'h01, 4'b0000);
    ev_pkt_ok = 1; expect_after("R5 double full", 8'h03, 4'b0000);
    ev_pkt_ok = 1; expect_after("R5 double overflow dropped", 8'h03, 4'b0000);
    wr(8'h10);  expect_after("R7 first flush", 8'h01, 4'b0001);
    wr(8'h10);  expect_after("R7 second flush", 8'h00, 4'b0001);
    wr(8'h10);  expect_after("R7 flush when empty ignored", 8'h00, 4'b0000);
    // R3 / R12 stall
    wr(8'h20);  expect_after("R4 request again", 8'h20, 4'b1000);
    ev_stall = 1; expect_after("R3 stall sets bit, irq", 8'h40, 4'b0010);
    wr(8'h60);  expect_after("R12 R3 request blocked, stall kept", 8'h40, 4'b0000);
    wr(8'h00);  expect_after("R3 software clears stall", 8'h00, 4'b0000);
    // R9 / R10 retry
    wr(8'h20);  expect_after("R10 request", 8'h20, 4'b1000);
    ev_timeout = 1; expect_after("R9 attempt 1", 8'h20, 4'b1000);
    ev_timeout = 1; expect_after("R9 attempt 2", 8'h20, 4'b1000);
    ev_pkt_ok = 1;  expect_after("R10 good packet resets tries", 8'h01, 4'b0000);
    sw_rd_done = 1; expect_after("R6 drain", 8'h00, 4'b0000);
    wr(8'h20);  expect_after("R10 request", 8'h20, 4'b1000);
    ev_timeout = 1; expect_after("R10 attempt 1 after packet", 8'h20, 4'b1000);
    ev_timeout = 1; expect_after("R10 attempt 2 after packet", 8'h20, 4'b1000);
    wr(8'h20);  expect_after("R10 new request resets tries", 8'h20, 4'b1000);
    ev_timeout = 1; expect_after("R10 attempt 1", 8'h20, 4'b1000);
    ev_timeout = 1; expect_after("R10 attempt 2", 8'h20, 4'b1000);
    ev_pkt_crc_err = 1; expect_after("R9 third failure sets error", 8'h04, 4'b0010);
    wr(8'h24);  expect_after("R9 write 1 keeps error", 8'h24, 4'b1000);
    wr(8'h00);  expect_after("R9 software clears error", 8'h00, 4'b0000);
    // R11 / R12 / R13 NAK timeout
    nak_limit = 5'd2;
    wr(8'h20);  expect_after("R11 request", 8'h20, 4'b1000);
    ev_nak = 1;   expect_after("R11 nak", 8'h20, 4'b1000);
    sof_tick = 1; expect_after("R11 frame 1", 8'h20, 4'b1000);
    sof_tick = 1; expect_after("R11 frame 2 expires", 8'h08, 4'b0000);
    wr(8'h28);  expect_after("R12 halt blocks request", 8'h08, 4'b0000);
    wr(8'h00);  expect_after("R13 bulk clear of bit 3", 8'h00, 4'b0000);
    wr(8'h20);  expect_after("R11 request", 8'h20, 4'b1000);
    ev_nak = 1;     expect_after("R11 nak", 8'h20, 4'b1000);
    sof_tick = 1;   expect_after("R11 frame 1", 8'h20, 4'b1000);
    ev_timeout = 1; expect_after("R11 other response", 8'h20, 4'b1000);
    sof_tick = 1;   expect_after("R11 restarted, no expire", 8'h20, 4'b1000);
    sof_tick = 1;   expect_after("R11 still no expire", 8'h20, 4'b1000);
    wr(8'h00);  expect_after("R11 cancel", 8'h00, 4'b0000);
    nak_limit = 5'd1;
    wr(8'h20);  expect_after("R11 request", 8'h20, 4'b1000);
    ev_nak = 1; expect_after("R11 nak", 8'h20, 4'b1000);
    for (int i = 0; i < 4; i++) begin
      sof_tick = 1; expect_after("R11 limit 1 disabled", 8'h20, 4'b1000);
    end
    wr(8'h00);  expect_after("R11 cancel", 8'h00, 4'b0000);
    // R8 / R13 / R9 isochronous
    cfg_iso = 1;
    ev_pkt_crc_err = 1; expect_after("R8 bad packet flags bit 3", 8'h09, 4'b0000);
    ev_pkt_ok = 1;      expect_after("R8 second packet", 8'h0B, 4'b0000);
    wr(8'h00);          expect_after("R13 iso write no effect", 8'h0B, 4'b0000);
    sw_rd_done = 1;     expect_after("R8 one left keeps bit 3", 8'h09, 4'b0000);
    sw_rd_done = 1;     expect_after("R8 empty clears bit 3", 8'h00, 4'b0000);
    for (int i = 0; i < 3; i++) begin
      ev_timeout = 1; expect_after("R9 iso timeouts ignored", 8'h00, 4'b0000);
    end
    @(negedge clk);
    @(negedge clk);
    done = 1;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule